// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate with Wait Timeout

This block turns host register accesses into byte-wide address or data cycles on an enhanced parallel port. The host talks to it through a small register window: a status offset, a control offset, an address-cycle offset and a data-cycle offset. Data-cycle accesses may be one, two or four bytes wide. A wide access is broken into single-byte peripheral cycles, lowest byte first. Each byte cycle raises an address or data strobe and holds it until the peripheral acknowledges. If no acknowledge arrives within `TIMEOUT_CYC` clocks, the cycle fails. A failure abandons any bytes still to go and sets a sticky timeout flag. The host reads that flag in bit 0 of the status offset and clears it by writing a 1 to that bit.

A cycle is started only when the control register holds an exact mode pattern. Any other pattern quietly discards the access. The control register drives the port's control lines. When a control write changes the transfer direction, the direction bit is updated one clock before the remaining bits. A control write that leaves the value unchanged finishes at once.

The host holds `hs_req` until `hs_ready` pulses, so the bus stalls for the whole access. The main state machine has these states:
- `ST_IDLE` accepts a request. It moves to `ST_STROBE` when a gated cycle may run. It moves to `ST_CTL_DIR` for a control write that flips the direction, and to `ST_CTL_SIG` for any other control write that changes the value. Every other access goes straight to `ST_DONE`.
- `ST_CTL_DIR` loads the direction bit and moves to `ST_CTL_SIG`.
- `ST_CTL_SIG` loads the remaining control bits and moves to `ST_DONE`.
- `ST_STROBE` holds the strobe. On an acknowledge it moves to `ST_GAP`. When the timer expires without one, it sets the flag and moves to `ST_DONE`.
- `ST_GAP` releases the strobe for one clock. It returns to `ST_STROBE` for the next byte, or moves to `ST_DONE` after the last byte.
- `ST_DONE` raises `hs_ready` for one clock and returns to `ST_IDLE`.

Top module: `epp_cycle_gate`

## Requirements
- R1: Reset leaves the timeout flag clear, the control register at 0xCC, both strobes low and `hs_ready` low.
- R2: Offset 3 runs exactly one byte cycle on `pp_addr_stb`. Offset 4 runs 1, 2 or 4 byte cycles on `pp_data_stb` for `hs_size` 0, 1 or 2/3. `pp_write` is 1 on writes and 0 on reads, and only one strobe is ever high.
- R3: A write at offset 3 or 4 runs only if control bits {5,3,2,1,0} are exactly 0,0,1,0,0, that is (ctrl & 0x2F) == 0x04. Otherwise no strobe is raised, the flag is unchanged, and `hs_ready` comes one clock after acceptance.
- R4: A read at offset 3 or 4 runs only if (ctrl & 0x2F) == 0x24. Otherwise it returns 0xFF in every byte lane of the access width, one clock after acceptance.
- R5: Byte k of a wide access, bits [8k+7:8k], goes on the k-th byte cycle. A read places the k-th received byte in that lane. Lanes above the access width read 0.
- R6: Each strobe is held until `pp_ack` is sampled high, then released for exactly one clock. An access of n bytes acknowledged after d extra clocks each reaches `hs_ready` 1 + n(d+2) clocks after acceptance.
- R7: A strobe unacknowledged for `TIMEOUT_CYC` clocks ends the access. It sets the flag and abandons the later bytes, and read lanes not received stay 0xFF.
- R8: A status read returns `ext_status` bits 7..1 with the timeout flag in bit 0.
- R9: A status write with bit 0 set clears the flag. With bit 0 clear, it leaves the flag alone.
- R10: Control writes store the value with bits 7 and 6 forced to 1. A write equal to the stored value completes in one clock.
- R11: A control write that changes bit 5 updates `pp_ctrl[5]` one clock before bits 4..0 and completes in three clocks. Other changing writes complete in two.
- R12: `hs_ready` is a single-clock pulse and never coincides with a strobe.
- R13: Offsets 0, 5, 6 and 7 ignore writes and read as 0xFF in the low lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_req | input | 1 | Host access request, held until hs_ready |
| hs_we | input | 1 | 1 = write, 0 = read |
| hs_ofs | input | 3 | Register offset |
| hs_size | input | 2 | Access width for offset 4: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| hs_wdata | input | 32 | Write data |
| hs_ready | output | 1 | One-clock completion pulse |
| hs_rdata | output | 32 | Read data, valid with hs_ready |
| pp_ctrl | output | 8 | Stored control register, driving the port control lines |
| pp_addr_stb | output | 1 | Address-cycle strobe |
| pp_data_stb | output | 1 | Data-cycle strobe |
| pp_write | output | 1 | Cycle direction while a strobe is high |
| pp_dout | output | 8 | Byte driven on write cycles |
| pp_din | input | 8 | Byte returned by the peripheral on read cycles |
| pp_ack | input | 1 | Peripheral acknowledge |
| ext_status | input | 8 | External status lines |

## Verification
All 64 control-bit combinations are swept. Each one is followed by a one-byte write and a four-byte read at the data offset. This separates the exact write pattern and the exact read pattern from near misses, such as bit 4 being ignored and the select or strobe bit closing the gate. It also shows the one-, two- and three-clock control-write latencies as the direction bit flips or stays put.

With a gate open, every access width on both cycle offsets is run with acknowledge delays from zero up to one past the timeout. This tells the last delay that succeeds apart from the first that fails. Partial acknowledge budgets stop a wide access part-way, which tests the byte order, which lanes still read as all ones, and the flag's set and clear behaviour. The bench also reads the status offset after each access, which tests the bit-0 override against different `ext_status` values.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTL_DIR,
        ST_CTL_SIG,
        ST_STROBE,
        ST_GAP,
        ST_DONE
    } gate_state_t;

    localparam logic [2:0] OFS_STATUS   = 3'd1;
    localparam logic [2:0] OFS_CONTROL  = 3'd2;
    localparam logic [2:0] OFS_ADDR_CYC = 3'd3;
    localparam logic [2:0] OFS_DATA_CYC = 3'd4;

    localparam int          CTRL_W          = 8;
    localparam int          CTRL_DIR_BIT    = 5;
    localparam logic [7:0]  CTRL_GATE_MASK  = 8'h2F;
    localparam logic [7:0]  CTRL_WR_PATTERN = 8'h04;
    localparam logic [7:0]  CTRL_RD_PATTERN = 8'h24;
    localparam logic [7:0]  CTRL_FORCED     = 8'hC0;
    localparam logic [7:0]  CTRL_RESET      = 8'hCC;

    // Number of byte lanes requested by a data-offset access.
    function automatic int lanes_for_size(input logic [1:0] sz);
        int n;
        unique case (sz)
            2'd0:    n = 1;
            2'd1:    n = 2;
            default: n = 4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/epp_ctrl_reg.sv
module epp_ctrl_reg #(
    parameter int                CTRL_W    = 8,
    parameter int                DIR_BIT   = 5,
    parameter logic [CTRL_W-1:0] RESET_VAL = 8'hCC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_dir,
    input  logic              load_rest,
    input  logic [CTRL_W-1:0] new_val,
    output logic [CTRL_W-1:0] ctrl_q
);

    // The direction bit has its own load strobe so it can be
    // committed ahead of the remaining control lines.
    for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
        if (b == DIR_BIT) begin : g_dir
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ctrl_q[b] <= RESET_VAL[b];
                else if (load_dir)
                    ctrl_q[b] <= new_val[b];
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ctrl_q[b] <= RESET_VAL[b];
                else if (load_rest)
                    ctrl_q[b] <= new_val[b];
            end
        end
    end

endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    // High in the last clock of the allowed strobe window.
    assign expire = run && (cnt_q == LAST);

endmodule

// File: rtl/epp_lane_buf.sv
module epp_lane_buf #(
    parameter int LANES = 4,
    parameter int IW    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 preset_en,
    input  logic [LANES*8-1:0]   preset_val,
    input  logic                 cap_en,
    input  logic [IW-1:0]        cap_idx,
    input  logic [7:0]           cap_byte,
    output logic [LANES*8-1:0]   word_q
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[l*8 +: 8] <= 8'hFF;
            else if (preset_en)
                word_q[l*8 +: 8] <= preset_val[l*8 +: 8];
            else if (cap_en && (cap_idx == IW'(l)))
                word_q[l*8 +: 8] <= cap_byte;
        end
    end

endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
    import epp_gate_pkg::*;
#(
    parameter int DATA_BYTES  = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hs_req,
    input  logic        hs_we,
    input  logic [2:0]  hs_ofs,
    input  logic [1:0]  hs_size,
    input  logic [31:0] hs_wdata,
    output logic        hs_ready,
    output logic [31:0] hs_rdata,
    output logic [7:0]  pp_ctrl,
    output logic        pp_addr_stb,
    output logic        pp_data_stb,
    output logic        pp_write,
    output logic [7:0]  pp_dout,
    input  logic [7:0]  pp_din,
    input  logic        pp_ack,
    input  logic [7:0]  ext_status
);

    localparam int HOST_W = DATA_BYTES * 8;
    localparam int IW     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
    localparam int NW     = IW + 1;

    gate_state_t state_q, state_d;

    logic              is_rd_q;
    logic              is_addr_q;
    logic [IW-1:0]     idx_q;
    logic [IW-1:0]     last_idx_q;
    logic [NW-1:0]     acc_lanes_q;
    logic [HOST_W-1:0] wdata_q;
    logic [7:0]        ctrl_new_q;
    logic              flag_q;

    logic [7:0]        ctrl_q;
    logic              tmr_expire;
    logic [HOST_W-1:0] buf_word;

    // Decode of the request presented in ST_IDLE
    logic              accept;
    logic              wr_gate_open;
    logic              rd_gate_open;
    logic              cyc_ofs;
    logic              go_cycle;
    logic              ctl_write;
    logic [7:0]        ctl_val;
    logic              ctl_same;
    logic              ctl_dirchg;
    logic [NW-1:0]     acc_lanes;
    logic [7:0]        status_val;
    logic [HOST_W-1:0] preset_val;
    logic              cap_en;

    assign accept = (state_q == ST_IDLE) && hs_req;

    always_comb begin
        int n;
        wr_gate_open = (ctrl_q & CTRL_GATE_MASK) == CTRL_WR_PATTERN;
        rd_gate_open = (ctrl_q & CTRL_GATE_MASK) == CTRL_RD_PATTERN;
        cyc_ofs      = (hs_ofs == OFS_ADDR_CYC) || (hs_ofs == OFS_DATA_CYC);
        go_cycle     = cyc_ofs && (hs_we ? wr_gate_open : rd_gate_open);
        ctl_write    = hs_we && (hs_ofs == OFS_CONTROL);
        ctl_val      = hs_wdata[7:0] | CTRL_FORCED;
        ctl_same     = ctl_val == ctrl_q;
        ctl_dirchg   = ctl_val[CTRL_DIR_BIT] != ctrl_q[CTRL_DIR_BIT];

        n = (hs_ofs == OFS_DATA_CYC) ? lanes_for_size(hs_size) : 1;
        if (n > DATA_BYTES)
            n = DATA_BYTES;
        acc_lanes = NW'(n);

        status_val    = ext_status;
        status_val[0] = flag_q;

        preset_val = '1;
        if (hs_ofs == OFS_STATUS)
            preset_val[7:0] = status_val;
        else if (hs_ofs == OFS_CONTROL)
            preset_val[7:0] = ctrl_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hs_req) begin
                    if (go_cycle)
                        state_d = ST_STROBE;
                    else if (ctl_write && !ctl_same)
                        state_d = ctl_dirchg ? ST_CTL_DIR : ST_CTL_SIG;
                    else
                        state_d = ST_DONE;
                end
            end
            ST_CTL_DIR: state_d = ST_CTL_SIG;
            ST_CTL_SIG: state_d = ST_DONE;
            ST_STROBE: begin
                if (pp_ack)
                    state_d = ST_GAP;
                else if (tmr_expire)
                    state_d = ST_DONE;
            end
            ST_GAP:  state_d = (idx_q == last_idx_q) ? ST_DONE : ST_STROBE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Access context captured on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_rd_q     <= 1'b0;
            is_addr_q   <= 1'b0;
            idx_q       <= '0;
            last_idx_q  <= '0;
            acc_lanes_q <= NW'(1);
            wdata_q     <= '0;
            ctrl_new_q  <= CTRL_RESET;
        end else if (accept) begin
            is_rd_q     <= !hs_we;
            is_addr_q   <= hs_ofs == OFS_ADDR_CYC;
            idx_q       <= '0;
            last_idx_q  <= IW'(acc_lanes - NW'(1));
            acc_lanes_q <= acc_lanes;
            wdata_q     <= hs_wdata[HOST_W-1:0];
            ctrl_new_q  <= ctl_val;
        end else if ((state_q == ST_GAP) && (idx_q != last_idx_q)) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Sticky timeout flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (accept && hs_we && (hs_ofs == OFS_STATUS) && hs_wdata[0])
            flag_q <= 1'b0;
        else if ((state_q == ST_STROBE) && !pp_ack && tmr_expire)
            flag_q <= 1'b1;
    end

    assign cap_en = (state_q == ST_STROBE) && pp_ack && is_rd_q;

    epp_ctrl_reg #(
        .CTRL_W    (CTRL_W),
        .DIR_BIT   (CTRL_DIR_BIT),
        .RESET_VAL (CTRL_RESET)
    ) u_ctrl_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_dir  (state_q == ST_CTL_DIR),
        .load_rest (state_q == ST_CTL_SIG),
        .new_val   (ctrl_new_q),
        .ctrl_q    (ctrl_q)
    );

    epp_wait_timer #(
        .LIMIT  (TIMEOUT_CYC)
    ) u_wait_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_STROBE),
        .expire (tmr_expire)
    );

    epp_lane_buf #(
        .LANES      (DATA_BYTES),
        .IW         (IW)
    ) u_lane_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset_en  (accept),
        .preset_val (preset_val),
        .cap_en     (cap_en),
        .cap_idx    (idx_q),
        .cap_byte   (pp_din),
        .word_q     (buf_word)
    );

    // Output logic
    always_comb begin
        hs_ready    = state_q == ST_DONE;
        pp_ctrl     = ctrl_q;
        pp_addr_stb = (state_q == ST_STROBE) && is_addr_q;
        pp_data_stb = (state_q == ST_STROBE) && !is_addr_q;
        pp_write    = (state_q == ST_STROBE) && !is_rd_q;
        pp_dout     = '0;
        if ((state_q == ST_STROBE) && !is_rd_q)
            pp_dout = wdata_q[{idx_q, 3'b000} +: 8];
        hs_rdata = '0;
        for (int l = 0; l < DATA_BYTES; l++) begin
            if (NW'(l) < acc_lanes_q)
                hs_rdata[l*8 +: 8] = buf_word[l*8 +: 8];
        end
    end

endmodule

// File: rtl/epp_gate_checker.sv
module epp_gate_checker #(
    parameter int TIMEOUT_CYC = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_ready,
    input logic [7:0] pp_ctrl,
    input logic       pp_addr_stb,
    input logic       pp_data_stb,
    input logic       pp_write,
    input logic       pp_ack
);

    localparam int WW = $clog2(TIMEOUT_CYC + 2);

    logic          stb;
    logic [WW-1:0] nack_q;

    assign stb = pp_addr_stb || pp_data_stb;

    // Consecutive strobe clocks without an acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            nack_q <= '0;
        else if (stb && !pp_ack)
            nack_q <= nack_q + 1'b1;
        else
            nack_q <= '0;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pp_addr_stb && pp_data_stb)); // R2
    AST_WRITE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && pp_write) |-> ((pp_ctrl & 8'h2F) == 8'h04)); // R3
    AST_READ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !pp_write) |-> ((pp_ctrl & 8'h2F) == 8'h24)); // R4
    AST_WAIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> (nack_q < WW'(TIMEOUT_CYC))); // R7
    AST_CTRL_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        pp_ctrl[7:6] == 2'b11); // R10
    AST_DIR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_ctrl[5] != $past(pp_ctrl[5])) |-> (pp_ctrl[4:0] == $past(pp_ctrl[4:0]))); // R11
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ready |=> !hs_ready); // R12
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ready |-> !stb); // R12

endmodule

bind epp_cycle_gate epp_gate_checker #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_epp_gate_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_ready    (hs_ready),
    .pp_ctrl     (pp_ctrl),
    .pp_addr_stb (pp_addr_stb),
    .pp_data_stb (pp_data_stb),
    .pp_write    (pp_write),
    .pp_ack      (pp_ack)
);

// File: tb/test_epp_cycle_gate.sv
`timescale 1ns/1ps
module test_epp_cycle_gate;

    localparam int TMO = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_req = 1'b0;
    logic        hs_we = 1'b0;
    logic [2:0]  hs_ofs = '0;
    logic [1:0]  hs_size = '0;
    logic [31:0] hs_wdata = '0;
    logic        hs_ready;
    logic [31:0] hs_rdata;
    logic [7:0]  pp_ctrl;
    logic        pp_addr_stb;
    logic        pp_data_stb;
    logic        pp_write;
    logic [7:0]  pp_dout;
    logic [7:0]  pp_din = 8'h00;
    logic        pp_ack = 1'b0;
    logic [7:0]  ext_status = 8'h5A;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Peripheral model state
    int         ack_delay = 0;
    int         ack_left = 0;
    int         stb_cnt = 0;
    int         log_n = 0;
    logic [7:0] log_byte [0:1023];
    bit         log_isaddr [0:1023];
    bit         log_wr [0:1023];
    logic [7:0] snap2;

    always #4 clk = ~clk;

    epp_cycle_gate #(
        .DATA_BYTES  (4),
        .TIMEOUT_CYC (TMO)
    ) i_epp_cycle_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_req      (hs_req),
        .hs_we       (hs_we),
        .hs_ofs      (hs_ofs),
        .hs_size     (hs_size),
        .hs_wdata    (hs_wdata),
        .hs_ready    (hs_ready),
        .hs_rdata    (hs_rdata),
        .pp_ctrl     (pp_ctrl),
        .pp_addr_stb (pp_addr_stb),
        .pp_data_stb (pp_data_stb),
        .pp_write    (pp_write),
        .pp_dout     (pp_dout),
        .pp_din      (pp_din),
        .pp_ack      (pp_ack),
        .ext_status  (ext_status)
    );

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary_and_end();
        end
    end

    // Peripheral: acknowledges after ack_delay strobe clocks while budget remains
    always @(negedge clk) begin
        if (pp_addr_stb || pp_data_stb) begin
            stb_cnt++;
            if (!pp_ack && ack_left > 0 && stb_cnt > ack_delay) begin
                pp_ack = 1'b1;
                pp_din = log_n[7:0] ^ 8'h5C;
                if (log_n < 1024) begin
                    log_byte[log_n]   = pp_dout;
                    log_isaddr[log_n] = pp_addr_stb;
                    log_wr[log_n]     = pp_write;
                end
                log_n++;
                ack_left--;
            end
        end else begin
            stb_cnt = 0;
            pp_ack  = 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [2:0] ofs, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        hs_req = 1'b1; hs_we = we; hs_ofs = ofs; hs_size = sz; hs_wdata = wd;
        lat = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (lat == 2) snap2 = pp_ctrl;
        end while (!hs_ready && lat < 200);
        rd = hs_rdata;
        hs_req = 1'b0;
        @(negedge clk);
        check("R12 ready single pulse", {31'b0, hs_ready}, 32'b0);
    endtask

    task automatic read_status(output logic [7:0] st);
        logic [31:0] r;
        int lat;
        access(1'b0, 3'd1, 2'd0, 32'h0, r, lat);
        st = r[7:0];
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        logic [31:0] r;
        int lat;
        access(1'b1, 3'd2, 2'd0, {24'h0, v}, r, lat);
    endtask

    task automatic cyc_test(input bit rd, input logic [2:0] ofs, input logic [1:0] sz,
                            input int d, input int budget, input bit open,
                            input logic [31:0] wd);
        int n, j, start, lat;
        bit to;
        logic [31:0] r, expw;
        logic [7:0] st;
        n = (ofs == 3'd4) ? ((sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4) : 1;
        if (!open || d >= TMO) j = 0;
        else j = (budget < n) ? budget : n;
        to = open && (j < n);
        start = log_n;
        ack_delay = d;
        ack_left = budget;
        access(!rd, ofs, sz, wd, r, lat);
        ack_left = 0;
        if (!open)
            check(rd ? "R4 gated read latency" : "R3 gated write latency", lat, 1);
        else
            check("R6 cycle latency", lat, 1 + j * (d + 2) + (to ? TMO : 0));
        check(open ? "R2 acked byte count" : "R3 no cycle when gated", log_n - start, j);
        for (int k = 0; k < j; k++) begin
            check("R2 strobe kind", {31'b0, log_isaddr[start+k]}, {31'b0, ofs == 3'd3});
            check("R2 write flag", {31'b0, log_wr[start+k]}, {31'b0, !rd});
            if (!rd)
                check("R5 write byte order", {24'b0, log_byte[start+k]}, {24'b0, wd[8*k +: 8]});
        end
        if (rd) begin
            expw = '0;
            for (int l = 0; l < 4; l++) begin
                if (l < n)
                    expw[8*l +: 8] = (l < j) ? (8'(start + l) ^ 8'h5C) : 8'hFF;
            end
            check(open ? (to ? "R7 partial read lanes" : "R5 read lanes") : "R4 gated read value",
                  r, expw);
        end
        read_status(st);
        check(to ? "R7 flag set on timeout" : "R7 flag clear without timeout",
              {31'b0, st[0]}, {31'b0, to});
        check("R8 status upper bits", {24'b0, st[7:1], 1'b0}, {24'b0, ext_status[7:1], 1'b0});
        if (to) begin
            access(1'b1, 3'd1, 2'd0, 32'hFE, r, lat);
            read_status(st);
            check("R9 bit0 clear keeps flag", {31'b0, st[0]}, 32'd1);
            access(1'b1, 3'd1, 2'd0, 32'h01, r, lat);
            read_status(st);
            check("R9 bit0 set clears flag", {31'b0, st[0]}, 32'd0);
        end
    endtask

    initial begin
        logic [31:0] r;
        int lat;
        logic [7:0] prev, nv, st;

        repeat (3) @(negedge clk);
        check("R1 ready low in reset", {31'b0, hs_ready}, 32'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 control reset value", {24'b0, pp_ctrl}, 32'hCC);
        check("R1 strobes low", {30'b0, pp_addr_stb, pp_data_stb}, 32'b0);
        check("R1 ready low", {31'b0, hs_ready}, 32'b0);
        read_status(st);
        check("R1 flag clear after reset", {31'b0, st[0]}, 32'b0);
        ext_status = 8'hA7;
        read_status(st);
        check("R8 bit0 overrides external", {24'b0, st}, 32'hA6);
        access(1'b0, 3'd2, 2'd0, 32'h0, r, lat);
        check("R1 control read", r, 32'hCC);

        // Exhaustive sweep of the control field
        prev = 8'hCC;
        for (int c = 0; c < 64; c++) begin
            nv = 8'(c) | 8'hC0;
            access(1'b1, 3'd2, 2'd0, 32'(c), r, lat);
            if (nv == prev)
                check("R10 unchanged control latency", lat, 1);
            else if (nv[5] != prev[5]) begin
                check("R11 direction change latency", lat, 3);
                check("R11 direction leads", {24'b0, snap2}, {24'b0, prev[7:6], nv[5], prev[4:0]});
            end else
                check("R11 plain control latency", lat, 2);
            access(1'b0, 3'd2, 2'd0, 32'h0, r, lat);
            check("R10 control readback", r, {24'b0, nv});
            prev = nv;
            cyc_test(1'b0, 3'd4, 2'd0, 0, 4, (nv & 8'h2F) == 8'h04, 32'h0000_0011 + 32'(c));
            cyc_test(1'b1, 3'd4, 2'd2, 0, 4, (nv & 8'h2F) == 8'h24, 32'h0);
        end

        // Width and delay sweep with the gates open
        ext_status = 8'h30;
        for (int rdm = 0; rdm < 2; rdm++) begin
            set_ctrl(rdm != 0 ? 8'h24 : 8'h04);
            for (int o = 3; o <= 4; o++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    for (int d = 0; d <= TMO; d++) begin
                        cyc_test(rdm != 0, 3'(o), 2'(sz), d, 4, 1'b1,
                                 32'h8765_4321 ^ (32'(d) << (8 * sz)));
                    end
                end
            end
            for (int b = 1; b < 4; b++)
                cyc_test(rdm != 0, 3'd4, 2'd2, 1, b, 1'b1, 32'hA1B2_C3D4);
            cyc_test(rdm != 0, 3'd4, 2'd1, 2, 1, 1'b1, 32'h0000_5566);
            cyc_test(rdm != 0, 3'd4, 2'd3, 0, 4, 1'b1, 32'hDEAD_BEEF);
        end

        // Unused offsets, in both open modes
        for (int rdm = 0; rdm < 2; rdm++) begin
            set_ctrl(rdm != 0 ? 8'h24 : 8'h04);
            for (int o = 0; o < 8; o++) begin
                if (o == 0 || o >= 5) begin
                    int start;
                    start = log_n;
                    ack_left = 4;
                    access(1'b1, 3'(o), 2'd2, 32'h0000_0000, r, lat);
                    check("R13 ignored write latency", lat, 1);
                    access(1'b0, 3'(o), 2'd2, 32'h0, r, lat);
                    ack_left = 0;
                    check("R13 unused read value", r, 32'h0000_00FF);
                    check("R13 no cycle", log_n - start, 0);
                    check("R13 control untouched", {24'b0, pp_ctrl}, rdm != 0 ? 32'hE4 : 32'hC4);
                    read_status(st);
                    check("R13 flag untouched", {31'b0, st[0]}, 32'b0);
                end
            end
        end

        // Reset with the flag set and a non-default control value
        set_ctrl(8'h04);
        cyc_test(1'b0, 3'd3, 2'd0, TMO + 1, 0, 1'b1, 32'h0);
        ack_delay = TMO + 1;
        access(1'b1, 3'd3, 2'd0, 32'h0, r, lat);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 control after mid-run reset", {24'b0, pp_ctrl}, 32'hCC);
        read_status(st);
        check("R1 flag after mid-run reset", {31'b0, st[0]}, 32'b0);

        summary_and_end();
    end

endmodule